// File: doc/BRIEF.md
# Sleep-Mode Entry and Power-Off Controller

This block sits between a processor core and the chip's clock gates and supply controls. When the core issues a sleep strobe, the block reads the registered sleep-mode code and the sleep-enable bit and picks a low-power state. It then drives per-domain clock enables, a request to switch the regulator off, a gate on the watchdog enable and a reset request.

Three codes are live. Code 000 (idle) stops only the core clock. Code 011 (power-save) stops the core and peripheral clocks and keeps the always-on timer domain running. Code 100 (power-off) stops every clock and asks for the regulator to be switched off. Power-off is a hazardous step, so it is guarded. The strobe must come within a short window after the mode code is written, and leaving power-off does not resume execution: the block issues a one-cycle reset request instead.

Wake sources are level signals. Each one must stay high for a configurable number of consecutive cycles before it counts. After a mode that stops the oscillator, the core clock returns only once a programmable start-up count has run out. The block itself runs on the always-on clock.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en`, `io_clk_en` and `aon_clk_en` are 1, `regulator_off` and `reset_req` are 0, and `wdt_gate` equals `wdt_en_cfg`.
- R2: A `sleep_strobe` while `sleep_en` is 0 changes nothing. All three clock enables stay 1.
- R3: With mode code 000 and `sleep_en` set, the strobe clears `cpu_clk_en` only. Once a wake level has been held, `cpu_clk_en` returns on the (H+1)-th rising edge after the level first rises, where H is `hold_cfg`. There is no start-up delay.
- R4: With mode code 011, the strobe clears `cpu_clk_en` and `io_clk_en` and keeps `aon_clk_en` at 1. After a held wake, `cpu_clk_en` returns on edge H+2+D, where D is `startup_cfg`.
- R5: With mode code 100, a strobe whose clock edge is 1 to 4 edges after the edge that registered the write clears all three clock enables and sets `regulator_off`.
- R6: A code-100 strobe 5 or more edges after the write leaves the block active, with all clocks enabled. Every mode write restarts the window.
- R7: In power-off, wake inputs other than bit 0 (charger detect) are ignored. `regulator_off` stays 1 and `reset_req` stays 0.
- R8: Leaving power-off, `regulator_off` falls and `reset_req` is 1 for exactly one cycle, seen after edge H+2+D. `cpu_clk_en` returns one edge later.
- R9: `wdt_gate` follows `wdt_en_cfg` in every state except power-off, where it is 0.
- R10: A wake level held for fewer than H consecutive cycles is not accepted, and the block stays asleep.
- R11: Mode codes 001, 010, 101, 110 and 111 make a sleep strobe a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the sleep-mode code |
| mode_in | input | 3 | Sleep-mode code written on `mode_wr` |
| sleep_en | input | 1 | Sleep enable, sampled with the strobe |
| sleep_strobe | input | 1 | One-cycle sleep request from the core |
| wake_lvl | input | N_WAKE | Level wake sources; bit 0 is charger detect |
| hold_cfg | input | HOLD_W | Required wake hold, in cycles (1 or more) |
| startup_cfg | input | DLY_W | Oscillator start-up count |
| wdt_en_cfg | input | 1 | Watchdog enable from configuration |
| cpu_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | 1 | Peripheral clock enable |
| aon_clk_en | output | 1 | Always-on timer domain clock enable |
| regulator_off | output | 1 | Request to shut the regulator off |
| wdt_gate | output | 1 | Gated watchdog enable |
| reset_req | output | 1 | Device reset request on power-off exit |

## Verification
A wrong state value shows up at the clock enables in the same cycle, because every output is decoded straight from the state register. A bad guard count shows up as power-off being entered or refused one edge off the 4-edge boundary. A start-up or hold counter that is off by one moves the return of `cpu_clk_en` by one edge, which the bench catches by counting edges from the moment the wake level rises. A power-off exit that skips the reset step, or holds it too long, shows up directly as the width and position of the `reset_req` pulse.

// File: rtl/slp_pkg.sv
package slp_pkg;

   localparam logic [2:0] MODE_IDLE = 3'b000;
   localparam logic [2:0] MODE_SAVE = 3'b011;
   localparam logic [2:0] MODE_OFF  = 3'b100;

   typedef enum logic [2:0] {
      ST_RUN  = 3'd0,
      ST_IDLE = 3'd1,
      ST_SAVE = 3'd2,
      ST_OFF  = 3'd3,
      ST_WARM = 3'd4,
      ST_RSTX = 3'd5
   } slp_state_e;

   typedef struct packed {
      logic cpu;
      logic io;
      logic aon;
   } clk_en_t;

endpackage

// File: rtl/slp_guard.sv
module slp_guard #(
   parameter int GUARD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic code_is_off,
   input  logic consume,
   output logic armed
);
   localparam int GW = $clog2(GUARD_CYC + 1);

   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("slp_guard: GUARD_CYC must be at least 1");
   end

   logic [GW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr) begin
         cnt_q <= code_is_off ? GW'(GUARD_CYC) : '0;
      end else if (consume) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign armed = (cnt_q != '0);
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter #(
   parameter int HOLD_W      = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              lvl,
   input  logic [HOLD_W-1:0] hold,
   output logic              qual
);
   logic lvl_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign lvl_s = lvl;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr_q <= '0;
         else        sr_q <= {sr_q[SYNC_STAGES-2:0], lvl};
      end
      assign lvl_s = sr_q[SYNC_STAGES-1];
   end

   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable || !lvl_s) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign qual = enable && (cnt_q != '0) && (cnt_q >= hold);
endmodule

// File: rtl/slp_warmup_timer.sv
module slp_warmup_timer #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] cfg,
   input  logic             run,
   output logic             done
);
   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= cfg;
      end else if (run && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
   import slp_pkg::*;
#(
   parameter int GUARD_CYC   = 4,
   parameter int DLY_W       = 16,
   parameter int HOLD_W      = 4,
   parameter int N_WAKE      = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_in,
   input  logic              sleep_en,
   input  logic              sleep_strobe,
   input  logic [N_WAKE-1:0] wake_lvl,
   input  logic [HOLD_W-1:0] hold_cfg,
   input  logic [DLY_W-1:0]  startup_cfg,
   input  logic              wdt_en_cfg,
   output logic              cpu_clk_en,
   output logic              io_clk_en,
   output logic              aon_clk_en,
   output logic              regulator_off,
   output logic              wdt_gate,
   output logic              reset_req
);
   localparam int CHG_IDX = 0;

   if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
      $error("sleep_ctrl: DLY_W must be 1..32");
   end
   if (HOLD_W < 1) begin : g_bad_hold
      $error("sleep_ctrl: HOLD_W must be at least 1");
   end
   if (N_WAKE < 1) begin : g_bad_wake
      $error("sleep_ctrl: N_WAKE must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES == 1 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("sleep_ctrl: SYNC_STAGES must be 0, 2 or 3");
   end

   slp_state_e  state_q, state_d;
   logic [2:0]  mode_q;
   logic        from_off_q;
   logic        armed;
   logic        go;
   logic        consume;
   logic        asleep;
   logic        warm_done;
   logic        warm_load;
   logic [N_WAKE-1:0] qual;
   logic        wake_any;
   logic        wake_chg;
   clk_en_t     ce;

   // mode register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mode_q <= MODE_IDLE;
      else if (state_q == ST_RSTX) mode_q <= MODE_IDLE;
      else if (mode_wr)            mode_q <= mode_in;
   end

   assign go      = sleep_strobe && sleep_en && (state_q == ST_RUN);
   assign consume = go || (state_q == ST_RSTX);

   slp_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (mode_wr),
      .code_is_off (mode_in == MODE_OFF),
      .consume     (consume),
      .armed       (armed)
   );

   assign asleep = (state_q == ST_IDLE) || (state_q == ST_SAVE) || (state_q == ST_OFF);

   for (genvar i = 0; i < N_WAKE; i++) begin : g_wake
      slp_wake_filter #(.HOLD_W(HOLD_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (asleep),
         .lvl    (wake_lvl[i]),
         .hold   (hold_cfg),
         .qual   (qual[i])
      );
   end

   assign wake_any = |qual;
   assign wake_chg = qual[CHG_IDX];

   // next state
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (go) begin
               case (mode_q)
                  MODE_IDLE: state_d = ST_IDLE;
                  MODE_SAVE: state_d = ST_SAVE;
                  MODE_OFF:  state_d = armed ? ST_OFF : ST_RUN;
                  default:   state_d = ST_RUN;
               endcase
            end
         end
         ST_IDLE: if (wake_any)  state_d = ST_RUN;
         ST_SAVE: if (wake_any)  state_d = ST_WARM;
         ST_OFF:  if (wake_chg)  state_d = ST_WARM;
         ST_WARM: if (warm_done) state_d = from_off_q ? ST_RSTX : ST_RUN;
         ST_RSTX: state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     from_off_q <= 1'b0;
      else if (state_q == ST_OFF && state_d == ST_WARM) from_off_q <= 1'b1;
      else if (state_q == ST_RSTX)                    from_off_q <= 1'b0;
   end

   assign warm_load = (state_d == ST_WARM) && (state_q != ST_WARM);

   slp_warmup_timer #(.DLY_W(DLY_W)) u_warm (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (warm_load),
      .cfg   (startup_cfg),
      .run   (state_q == ST_WARM),
      .done  (warm_done)
   );

   // output decode
   always_comb begin
      unique case (state_q)
         ST_RUN:  ce = '{cpu: 1'b1, io: 1'b1, aon: 1'b1};
         ST_IDLE: ce = '{cpu: 1'b0, io: 1'b1, aon: 1'b1};
         ST_SAVE: ce = '{cpu: 1'b0, io: 1'b0, aon: 1'b1};
         ST_OFF:  ce = '{cpu: 1'b0, io: 1'b0, aon: 1'b0};
         ST_WARM: ce = '{cpu: 1'b0, io: 1'b0, aon: 1'b1};
         ST_RSTX: ce = '{cpu: 1'b0, io: 1'b1, aon: 1'b1};
         default: ce = '{cpu: 1'b1, io: 1'b1, aon: 1'b1};
      endcase
   end

   assign cpu_clk_en    = ce.cpu;
   assign io_clk_en     = ce.io;
   assign aon_clk_en    = ce.aon;
   assign regulator_off = (state_q == ST_OFF);
   assign wdt_gate      = wdt_en_cfg && (state_q != ST_OFF);
   assign reset_req     = (state_q == ST_RSTX);
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_en,
   input logic sleep_strobe,
   input logic wdt_en_cfg,
   input logic cpu_clk_en,
   input logic io_clk_en,
   input logic aon_clk_en,
   input logic regulator_off,
   input logic wdt_gate,
   input logic reset_req
);
   assert_off_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      regulator_off |-> (!cpu_clk_en && !io_clk_en && !aon_clk_en));

   assert_off_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(regulator_off) |-> $past(sleep_strobe && sleep_en));

   assert_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && sleep_strobe && !sleep_en) |=> cpu_clk_en);

   assert_cpu_needs_io_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !io_clk_en |-> !cpu_clk_en);

   assert_warm_after_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(regulator_off) |-> !cpu_clk_en);

   assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (!cpu_clk_en && !regulator_off));

   assert_wdt_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      regulator_off |-> !wdt_gate);

   assert_wdt_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !regulator_off |-> (wdt_gate == wdt_en_cfg));
endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sleep_en      (sleep_en),
   .sleep_strobe  (sleep_strobe),
   .wdt_en_cfg    (wdt_en_cfg),
   .cpu_clk_en    (cpu_clk_en),
   .io_clk_en     (io_clk_en),
   .aon_clk_en    (aon_clk_en),
   .regulator_off (regulator_off),
   .wdt_gate      (wdt_gate),
   .reset_req     (reset_req)
);

// File: tb/sleep_ctrl_tb.sv
module sleep_ctrl_tb;
   localparam int GUARD  = 4;
   localparam int DLY_W  = 16;
   localparam int HOLD_W = 4;
   localparam int N_WAKE = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_wr = 1'b0;
   logic [2:0]        mode_in = 3'b000;
   logic              sleep_en = 1'b0;
   logic              sleep_strobe = 1'b0;
   logic [N_WAKE-1:0] wake_lvl = '0;
   logic [HOLD_W-1:0] hold_cfg = 4'd1;
   logic [DLY_W-1:0]  startup_cfg = '0;
   logic              wdt_en_cfg = 1'b1;
   logic              cpu_clk_en, io_clk_en, aon_clk_en;
   logic              regulator_off, wdt_gate, reset_req;

   int vectors = 0;
   int fails   = 0;

   always #2 clk = ~clk;

   sleep_ctrl #(.GUARD_CYC(GUARD), .DLY_W(DLY_W), .HOLD_W(HOLD_W), .N_WAKE(N_WAKE)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
      .sleep_en(sleep_en), .sleep_strobe(sleep_strobe), .wake_lvl(wake_lvl),
      .hold_cfg(hold_cfg), .startup_cfg(startup_cfg), .wdt_en_cfg(wdt_en_cfg),
      .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .aon_clk_en(aon_clk_en),
      .regulator_off(regulator_off), .wdt_gate(wdt_gate), .reset_req(reset_req)
   );

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected {cpu,io,aon} while asleep in a mode
   function automatic logic [2:0] exp_clk(input logic [2:0] mode);
      case (mode)
         3'b000:  return 3'b011;
         3'b011:  return 3'b001;
         3'b100:  return 3'b000;
         default: return 3'b111;
      endcase
   endfunction

   function automatic bit exp_enter(input logic [2:0] mode, input int gap, input bit en);
      if (!en) return 1'b0;
      if (mode == 3'b000 || mode == 3'b011) return 1'b1;
      if (mode == 3'b100) return (gap <= GUARD);
      return 1'b0;
   endfunction

   function automatic int exp_wake_edges(input logic [2:0] mode, input int hold, input int dly);
      if (mode == 3'b000) return hold + 1;
      if (mode == 3'b011) return hold + 2 + dly;
      return hold + 3 + dly;
   endfunction

   function automatic string entry_tag(input logic [2:0] mode, input bit en);
      if (!en) return "R2";
      case (mode)
         3'b000:  return "R3";
         3'b011:  return "R4";
         3'b100:  return "R5/R6";
         default: return "R11";
      endcase
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic apply(input logic [2:0] mode, input int gap, input bit en,
                        input int hold, input int dly, input int src, input bit short_p);
      bit          entered;
      logic [2:0]  ex;
      int          n;
      int          rst_at;
      int          s;
      hold_cfg    = HOLD_W'(hold);
      startup_cfg = DLY_W'(dly);
      mode_wr = 1'b1;
      mode_in = mode;
      step();
      mode_wr = 1'b0;
      repeat (gap - 1) step();
      sleep_strobe = 1'b1;
      sleep_en     = en;
      step();
      sleep_strobe = 1'b0;
      entered = exp_enter(mode, gap, en);
      ex = entered ? exp_clk(mode) : 3'b111;
      check(entry_tag(mode, en), int'({cpu_clk_en, io_clk_en, aon_clk_en}), int'(ex));
      check("R5", int'(regulator_off), int'(entered && mode == 3'b100));
      check("R9", int'(wdt_gate), int'(wdt_en_cfg && !(entered && mode == 3'b100)));
      if (!entered) return;

      if (short_p && hold >= 2) begin
         wake_lvl[0] = 1'b1;
         repeat (hold - 1) step();
         wake_lvl[0] = 1'b0;
         repeat (2) step();
         check("R10", int'({cpu_clk_en, io_clk_en, aon_clk_en}), int'(ex));
      end

      if (mode == 3'b100 && src != 0) begin
         wake_lvl[src] = 1'b1;
         repeat (hold + 3) step();
         check("R7", int'({regulator_off, reset_req}), 2);
         wake_lvl[src] = 1'b0;
         step();
      end

      s = (mode == 3'b100) ? 0 : src;
      wake_lvl[s] = 1'b1;
      n = 0;
      rst_at = 0;
      for (int k = 0; k < 400; k++) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (reset_req && rst_at == 0) rst_at = n;
         if (cpu_clk_en) break;
      end
      wake_lvl[s] = 1'b0;
      check(mode == 3'b000 ? "R3" : (mode == 3'b011 ? "R4" : "R8"),
            n, exp_wake_edges(mode, hold, dly));
      if (mode == 3'b100) begin
         check("R8", rst_at, hold + 2 + dly);
         check("R8", int'({regulator_off, reset_req}), 0);
      end
      step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C7A));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", int'({cpu_clk_en, io_clk_en, aon_clk_en}), 7);
      check("R1", int'({regulator_off, reset_req}), 0);
      check("R1", int'(wdt_gate), 1);
      rst_n = 1'b1;
      step();
      check("R1", int'({cpu_clk_en, io_clk_en, aon_clk_en}), 7);

      // directed corners
      apply(3'b000, 1, 1'b0, 1, 0, 0, 1'b0);   // R2 no-op
      apply(3'b000, 2, 1'b1, 1, 0, 1, 1'b0);   // R3 idle
      apply(3'b011, 1, 1'b1, 3, 5, 2, 1'b1);   // R4 save, R10 short pulse
      apply(3'b100, 4, 1'b1, 2, 3, 3, 1'b1);   // R5 last in window, R7, R8
      apply(3'b100, 5, 1'b1, 2, 3, 0, 1'b0);   // R6 first outside window
      apply(3'b100, 1, 1'b1, 1, 0, 1, 1'b0);   // R5 first in window
      apply(3'b110, 1, 1'b1, 1, 0, 0, 1'b0);   // R11 reserved
      apply(3'b001, 2, 1'b1, 1, 0, 0, 1'b0);   // R11 reserved
      wdt_en_cfg = 1'b0;
      apply(3'b100, 3, 1'b1, 1, 2, 2, 1'b0);   // R9 with watchdog off
      wdt_en_cfg = 1'b1;

      // constrained random
      for (int i = 0; i < 80; i++) begin
         logic [2:0] m;
         m = 3'($urandom % 8);
         if ($urandom % 2 == 0) m = ($urandom % 2 == 0) ? 3'b100 : 3'b011;
         wdt_en_cfg = 1'($urandom % 2);
         apply(m, 1 + int'($urandom % 7), ($urandom % 4) != 0,
               1 + int'($urandom % 5), int'($urandom % 12),
               int'($urandom % N_WAKE), 1'($urandom % 2));
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule